// File: doc/BRIEF.md
# Interrupt Mask Controller with Set/Clear Commands

This block gates 64 level-sensitive interrupt requests through a 64-bit mask register. A mask bit of 1 blocks its source. The block drives the vector of unmasked, asserted requests straight out. It also registers an any-interrupt flag and the index of the highest-numbered unmasked pending source.

Software changes the mask over a simple register bus in two ways. The first is to replace one 32-bit half with a word write. The second is a single-byte command to a set-mask or clear-mask port. Such a command either acts on one source, picked by a 6-bit index, or on all 64 sources at once, so no read-modify-write is needed. A write of the wrong size, or to an offset that is not decoded, raises a one-cycle error pulse and changes nothing.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset every mask bit is 1, so `pend` is zero, and `any_irq` and `bus_err` are 0.
- R2: A word write (`bus_byte`=0) at offset 0x0c loads `bus_wdata` into mask bits [31:0] and leaves bits [63:32] unchanged. A read at 0x0c returns mask bits [31:0].
- R3: A word write at offset 0x08 loads `bus_wdata` into mask bits [63:32] and leaves bits [31:0] unchanged. A read at 0x08 returns mask bits [63:32].
- R4: A byte write (`bus_byte`=1) at offset 0x1c with data bit 6 set drives all 64 mask bits to 1.
- R5: A byte write at 0x1c with data bit 6 clear sets only the mask bit whose index is data bits [5:0]. Data bit 7 is ignored.
- R6: A byte write at offset 0x1d with data bit 6 set clears all 64 mask bits to 0.
- R7: A byte write at 0x1d with data bit 6 clear clears only the mask bit whose index is data bits [5:0], and leaves every other bit unchanged.
- R8: `pend` equals `irq_req` with every masked source forced to 0.
- R9: One clock after a change of requests or mask, `any_irq` shows whether `pend` is nonzero. While it is 1, `top_idx` gives the highest set bit of `pend`.
- R10: A write to any other offset, or of the wrong size for its offset, pulses `bus_err` high for exactly one cycle after the write edge and leaves the mask unchanged. Reads at any offset other than 0x08 and 0x0c return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 64 | Level-sensitive interrupt requests |
| bus_addr | input | AW | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_byte | input | 1 | 1 = byte access, 0 = 32-bit word access |
| bus_wdata | input | 32 | Write data (byte commands use bits [7:0]) |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| bus_err | output | 1 | One-cycle pulse after a bad write |
| pend | output | 64 | Unmasked pending requests |
| any_irq | output | 1 | Registered: some request is pending |
| top_idx | output | 6 | Registered: highest pending index |

## Verification
The mask is driven by random mixes of half-word loads, single-bit set and clear commands, all-bits commands and bad writes. Each is checked against a bench model through readback and through `pend`. Single-bit commands at indices 0, 31, 32 and 63 separate a correct index decode from one that is off by one or tied to a single half. Commands with bit 7 set show that only bits [6:0] are decoded. Request patterns with one source, with none, and with random bits isolate the highest-index search and its one-cycle register delay.

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [63:0]   irq_req,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_byte,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          bus_err,
  output logic [63:0]   pend,
  output logic          any_irq,
  output logic [5:0]    top_idx
);
  localparam logic [AW-1:0] OFS_HI  = AW'(8'h08);
  localparam logic [AW-1:0] OFS_LO  = AW'(8'h0c);
  localparam logic [AW-1:0] OFS_SET = AW'(8'h1c);
  localparam logic [AW-1:0] OFS_CLR = AW'(8'h1d);

  logic [63:0] mask_q;
  logic [63:0] sel_bit;
  logic [5:0]  idx_c;

  wire wr_hi  = bus_wr && !bus_byte && bus_addr == OFS_HI;
  wire wr_lo  = bus_wr && !bus_byte && bus_addr == OFS_LO;
  wire wr_set = bus_wr &&  bus_byte && bus_addr == OFS_SET;
  wire wr_clr = bus_wr &&  bus_byte && bus_addr == OFS_CLR;
  wire all_op = bus_wdata[6];

  assign sel_bit = 64'(1) << bus_wdata[5:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_q <= '1;
    else if (wr_hi)  mask_q[63:32] <= bus_wdata;
    else if (wr_lo)  mask_q[31:0]  <= bus_wdata;
    else if (wr_set) mask_q <= all_op ? '1 : (mask_q | sel_bit);
    else if (wr_clr) mask_q <= all_op ? '0 : (mask_q & ~sel_bit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_err <= 1'b0;
    else        bus_err <= bus_wr && !(wr_hi || wr_lo || wr_set || wr_clr);
  end

  assign pend = irq_req & ~mask_q;

  always_comb begin
    idx_c = '0;
    for (int i = 0; i < 64; i++)
      if (pend[i]) idx_c = 6'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_irq <= 1'b0;
      top_idx <= '0;
    end else begin
      any_irq <= |pend;
      top_idx <= idx_c;
    end
  end

  assign bus_rdata = (bus_addr == OFS_HI) ? mask_q[63:32] :
                     (bus_addr == OFS_LO) ? mask_q[31:0]  : 32'h0;
endmodule

module irq_mask_ctrl_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic          bus_byte,
  input logic [31:0]   bus_wdata,
  input logic          bus_err,
  input logic [63:0]   pend,
  input logic          any_irq,
  input logic [63:0]   mask
);
  wire good = bus_byte ? (bus_addr == AW'(8'h1c) || bus_addr == AW'(8'h1d))
                       : (bus_addr == AW'(8'h08) || bus_addr == AW'(8'h0c));

  assert_lo_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_byte && bus_addr == AW'(8'h0c) |=>
      mask[31:0] == $past(bus_wdata) && mask[63:32] == $past(mask[63:32]));

  assert_hi_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_byte && bus_addr == AW'(8'h08) |=>
      mask[63:32] == $past(bus_wdata) && mask[31:0] == $past(mask[31:0]));

  assert_set_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_byte && bus_addr == AW'(8'h1c) && bus_wdata[6] |=> &mask);

  assert_clr_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_byte && bus_addr == AW'(8'h1d) && bus_wdata[6] |=> mask == 64'h0);

  assert_clr_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_byte && bus_addr == AW'(8'h1d) && !bus_wdata[6] |=>
      $countones(mask ^ $past(mask)) <= 1 && !mask[$past(bus_wdata[5:0])]);

  assert_any_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 any_irq == (|$past(pend)));

  assert_bad_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !good |=> bus_err && $stable(mask));

  assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && !good) |=> !bus_err);
endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_byte(bus_byte), .bus_wdata(bus_wdata), .bus_err(bus_err),
  .pend(pend), .any_irq(any_irq), .mask(mask_q)
);

// File: tb/irq_mask_ctrl_tb_top.sv
module irq_mask_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic clk = 0, rst_n = 0;
  logic [63:0] irq_req = '0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 0, bus_byte = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_err, any_irq;
  logic [63:0] pend;
  logic [5:0] top_idx;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [63:0] exp_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_mask_ctrl #(.AW(AW)) dut_i (.*);

  function automatic bit ok_write(logic [AW-1:0] a, logic b);
    return b ? (a == 8'h1c || a == 8'h1d) : (a == 8'h08 || a == 8'h0c);
  endfunction

  function automatic logic [63:0] next_mask(logic [63:0] m, logic [AW-1:0] a, logic b, logic [31:0] d);
    if (!ok_write(a, b)) return m;
    case (a)
      8'h08: return {d, m[31:0]};
      8'h0c: return {m[63:32], d};
      8'h1c: return d[6] ? {64{1'b1}} : (m | (64'd1 << d[5:0]));
      default: return d[6] ? 64'd0 : (m & ~(64'd1 << d[5:0]));
    endcase
  endfunction

  function automatic int top_of(logic [63:0] v);
    for (int i = 63; i >= 0; i--) if (v[i]) return i;
    return 0;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [AW-1:0] a, logic b, logic [31:0] d);
    bus_addr = a; bus_byte = b; bus_wdata = d; bus_wr = 1;
    @(posedge clk); @(negedge clk);
    bus_wr = 0;
    chk("R10 err", bus_err, !ok_write(a, b));
    exp_mask = next_mask(exp_mask, a, b, d);
    @(posedge clk); @(negedge clk);
    chk("R10 err pulse", bus_err, 0);
  endtask

  task automatic check_mask(string req);
    bus_addr = 8'h08; #1; chk({req, " hi"}, bus_rdata, exp_mask[63:32]);
    bus_addr = 8'h0c; #1; chk({req, " lo"}, bus_rdata, exp_mask[31:0]);
    chk("R8 pend", pend, irq_req & ~exp_mask);
  endtask

  task automatic check_out(string req);
    logic [63:0] p;
    p = irq_req & ~exp_mask;
    @(posedge clk); @(negedge clk);
    chk({req, " any"}, any_irq, |p);
    if (|p) chk({req, " idx"}, top_idx, top_of(p));
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    exp_mask = '1;
    irq_req = '1;
    repeat (3) @(negedge clk);
    chk("R1 pend", pend, 0); chk("R1 any", any_irq, 0); chk("R1 err", bus_err, 0);
    rst_n = 1; @(negedge clk);
    check_mask("R1 mask");

    bus_write(8'h0c, 0, 32'h0000_00f0); check_mask("R2");      check_out("R9");
    bus_write(8'h08, 0, 32'h8000_0001); check_mask("R3");      check_out("R9");
    bus_write(8'h1c, 1, 32'h40);        check_mask("R4");      check_out("R9");
    bus_write(8'h1d, 1, 32'h40);        check_mask("R6");      check_out("R9");
    bus_write(8'h1c, 1, 32'hbf);        check_mask("R5 bit7"); check_out("R9");
    foreach (irq_req[i]) irq_req[i] = 0;
    irq_req[0] = 1; irq_req[31] = 1; irq_req[32] = 1;
    check_out("R9 one");
    bus_write(8'h1c, 1, 32'h20);        check_mask("R5 idx32"); check_out("R9");
    bus_write(8'h1c, 1, 32'h1f);        check_mask("R5 idx31"); check_out("R9");
    bus_write(8'h1d, 1, 32'h3f);        check_mask("R7 idx63"); check_out("R9");
    bus_write(8'h1d, 1, 32'h80);        check_mask("R7 idx0");  check_out("R9");
    irq_req = '0; check_out("R9 none");
    bus_write(8'h0c, 1, 32'h1234);      check_mask("R10 size");
    bus_write(8'h1c, 0, 32'h40);        check_mask("R10 size");
    bus_write(8'h10, 0, 32'hffff);      check_mask("R10 ofs");
    bus_addr = 8'h1c; #1; chk("R10 rd set", bus_rdata, 0);
    bus_addr = 8'h1d; #1; chk("R10 rd clr", bus_rdata, 0);

    for (int n = 0; n < 300; n++) begin
      logic [AW-1:0] a;
      logic b;
      case ($urandom % 6)
        0: begin a = 8'h08; b = 0; end
        1: begin a = 8'h0c; b = 0; end
        2: begin a = 8'h1c; b = 1; end
        3, 4: begin a = 8'h1d; b = 1; end
        default: begin a = AW'($urandom); b = 1'($urandom); end
      endcase
      irq_req = {$urandom, $urandom};
      bus_write(a, b, (b && ($urandom % 4 != 0)) ? ($urandom & 32'hbf) : $urandom);
      check_mask("R2 R3 R5 R7 rand");
      check_out("R9 rand");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule